// File: doc/BRIEF.md
# String-Transition NFA State Circuit

This block holds the state-transition half of a pattern matcher whose automaton has been split in two. Runs of automaton states that carry no epsilon edges are collapsed into single merged states, each of which advances on a whole transition string rather than on one character. The string's characters may each be a character class. A separate string detector, which is not part of this block, consumes one character per valid cycle. On the cycle in which a transition string finishes, it raises that string's bit in a detection vector that has one bit per merged state.

Each merged state is one flip-flop. The state sets only when two things hold on the same valid character: its detection bit is high, and the activity of one of its predecessors was present exactly as many characters earlier as the string is long. To line the two up, a transition of length p passes its source activity through a p-1 stage shift register. That register advances only on valid characters. Which states feed which, the string lengths and the set of accepting states are all parameters. An implicit start source is always enabled, so a match may begin at any character position.

The default configuration recognises `A+[AB]{3}D`:
- Merged state 0 takes the one-character string `A`. It is fed by the start source and by itself, and the self-feed is what gives the repetition.
- Merged state 1 takes the four-character string `[AB][AB][AB]D`. It is fed by state 0 and is the accepting state.

Top module: `strnfa_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, every merged state and every shift-register stage is cleared, so `match` reads 0 until a full path has completed. The string `BBBD` after reset must not raise `match`.
- R2: The start source is enabled on every character. With default parameters, any valid character whose `det_vec[0]` bit is 1 sets state 0, whatever came before it.
- R3: A merged state is set after a valid cycle only if its detection bit (`det_vec[k]` for state k) was 1 in that cycle. Otherwise it is cleared.
- R4: A transition of string length p from a source that was active after valid character t sets its target only on valid character t+p, through p-1 stages. The default length of state 1 is 4, so `AABAD` raises `match` after the `D`.
- R5: A state listed as its own predecessor repeats. With default parameters, any number of `A` characters before `[AB][AB][AB]D` yields a match, and `match` after each character equals: the last four characters are `[AB][AB][AB]D` and the character before them is `A`.
- R6: Cycles with `det_valid` low neither shift any delay stage nor change any state, whatever `det_vec` holds. `match` keeps its value, and later alignment is unaffected.
- R7: `match` is the OR of the accepting states (default: state 1 only). It changes only in the cycle that follows a valid character.
- R8: A detection bit with no delayed predecessor activity has no effect. `det_vec[1]` asserted without a matching state-0 history four characters earlier leaves `match` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_valid | input | 1 | High when `det_vec` carries the detector result for one new character |
| det_vec | input | NSTATE | String-complete bits, bit k for merged state k |
| match | output | 1 | High while any accepting merged state is set |

## Verification
The assertions take for granted that `det_vec` is only meaningful when `det_valid` is high, and that both inputs are steady around each rising edge. The bench drives its inputs on falling edges only. Character stimulus runs through a bench model of the detector, so the detection bits are those a real detector would produce. A second random phase drives arbitrary detection vectors; this is legal here, because the block must ignore bits that lack predecessor history. Invalid cycles are mixed into both phases with random, meaningless `det_vec` contents.

// File: rtl/strnfa_pkg.sv
package strnfa_pkg;
    // width of one string-length field in the packed length parameter
    localparam int LEN_W = 8;
    typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/strnfa_delay_line.sv
module strnfa_delay_line #(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= (stage_q << 1) | DEPTH'(din);
        end
    end

    assign dout = stage_q[DEPTH-1];

    // R6: no shift on invalid characters
    assert_hold_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dout));
endmodule

// File: rtl/strnfa_state_cell.sv
module strnfa_state_cell #(
    parameter int unsigned STR_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chr_valid,
    input  logic src_en,
    input  logic str_done,
    output logic active
);
    logic aligned_en;

    generate
        if (STR_LEN > 1) begin : g_delay
            strnfa_delay_line #(.DEPTH(STR_LEN - 1)) u_dly (
                .clk     (clk),
                .rst_n   (rst_n),
                .shift_en(chr_valid),
                .din     (src_en),
                .dout    (aligned_en)
            );
        end else begin : g_direct
            assign aligned_en = src_en;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (chr_valid) begin
            active <= aligned_en & str_done;
        end
    end

    // R3: a missing detection bit clears the state
    assert_needs_det_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !str_done) |=> !active);
    // R8: detection without aligned predecessor activity has no effect
    assert_needs_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !aligned_en) |=> !active);
    // R6: state frozen on invalid cycles
    assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_valid |=> $stable(active));
endmodule

// File: rtl/strnfa_core.sv
module strnfa_core #(
    parameter int unsigned NSTATE = 2,
    // string length per merged state, state k in field k (LSB first)
    parameter logic [NSTATE*strnfa_pkg::LEN_W-1:0] STR_LEN = {8'd4, 8'd1},
    // predecessors per state: field k has NSTATE+1 bits,
    // bit 0 = always-on start source, bit j+1 = merged state j
    parameter logic [NSTATE*(NSTATE+1)-1:0] PRED_MASK = {3'b010, 3'b011},
    parameter logic [NSTATE-1:0] ACCEPT = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_valid,
    input  logic [NSTATE-1:0] det_vec,
    output logic              match
);
    localparam int unsigned SRC_W = NSTATE + 1;

    logic [NSTATE-1:0] st_active;
    logic [SRC_W-1:0]  src_vec;
    logic [NSTATE-1:0] src_en;

    // start source is enabled on every character (unanchored search)
    assign src_vec = {st_active, 1'b1};

    generate
        for (genvar k = 0; k < NSTATE; k++) begin : g_state
            localparam strnfa_pkg::len_t LEN_K =
                STR_LEN[k*strnfa_pkg::LEN_W +: strnfa_pkg::LEN_W];
            localparam logic [SRC_W-1:0] PRED_K = PRED_MASK[k*SRC_W +: SRC_W];

            assign src_en[k] = |(src_vec & PRED_K);

            strnfa_state_cell #(.STR_LEN(int'(LEN_K))) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .chr_valid(det_valid),
                .src_en   (src_en[k]),
                .str_done (det_vec[k]),
                .active   (st_active[k])
            );
        end
    endgenerate

    assign match = |(st_active & ACCEPT);

    // R7: match only changes after a valid character
    assert_match_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !det_valid |=> $stable(match));
    // R1: nothing is set in the first cycle after reset release
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (st_active == '0));
endmodule

// File: tb/tb_strnfa_core.sv
module tb_strnfa_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_valid = 1'b0;
    logic [1:0] det_vec = '0;
    logic       match;

    int total = 0;
    int bad = 0;
    int t = 0;
    logic [1:0] hist [0:1023];
    byte        chars [0:1023];

    always #2 clk = ~clk;

    strnfa_core dut (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid),
        .det_vec(det_vec), .match(match)
    );

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: match=%0b expected=%0b (char %0d)", tag, act, exp, t);
        end
    endtask

    // expected state vector after the valid character with index t
    function automatic logic [1:0] model(logic [1:0] d);
        logic [1:0] e;
        e[0] = d[0];                                  // start always enabled (R2)
        e[1] = d[1] && (t >= 4) && hist[t-4][0];      // length 4 from state 0 (R4)
        return e;
    endfunction

    task automatic step(logic v, logic [1:0] d, string tag);
        logic [1:0] e;
        logic prev;
        prev = match;
        det_valid = v;
        det_vec = d;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            e = model(d);
            hist[t] = e;
            t++;
            check(tag, match, e[1]);
        end else begin
            check("R6", match, prev);
        end
        det_valid = 1'b0;
        det_vec = '0;
    endtask

    function automatic logic is_ab(byte c);
        return (c == 8'h41) || (c == 8'h42);
    endfunction

    task automatic feed_char(byte c, string tag);
        logic [1:0] d;
        logic rx;
        chars[t] = c;
        d[0] = (c == 8'h41);
        d[1] = (t >= 3) && is_ab(chars[t-3]) && is_ab(chars[t-2]) &&
               is_ab(chars[t-1]) && (c == 8'h44);
        rx = (t >= 4) && d[1] && (chars[t-4] == 8'h41);
        step(1'b1, d, tag);
        check("R5", match, rx);
    endtask

    task automatic feed_str(string s, string tag);
        for (int i = 0; i < s.len(); i++) feed_char(s[i], tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        det_valid = 1'b0;
        det_vec = '0;
        repeat (3) @(negedge clk);
        check("R1", match, 1'b0);
        rst_n = 1'b1;
        t = 0;
        @(negedge clk);
        check("R1", match, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));

        // R1 and R8: no leading A, no match
        do_reset();
        feed_str("BBBD", "R8");
        check("R1", match, 1'b0);

        // R4: basic path
        do_reset();
        feed_str("AABAD", "R4");
        check("R4", match, 1'b1);
        feed_char(8'h43, "R7");
        check("R7", match, 1'b0);

        // R5: long repetition
        do_reset();
        feed_str("AAAAAAAABBBD", "R5");
        check("R5", match, 1'b1);

        // R6: invalid cycles carrying junk in the middle of a string
        do_reset();
        feed_str("AAB", "R6");
        step(1'b0, 2'b11, "R6");
        step(1'b0, 2'b10, "R6");
        feed_str("AD", "R6");
        check("R6", match, 1'b1);
        step(1'b0, 2'b00, "R6");
        check("R6", match, 1'b1);

        // R2 / R7: random characters with invalid gaps
        do_reset();
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 4 == 0) step(1'b0, 2'($urandom), "R6");
            feed_char(8'h41 + 8'($urandom % 4), "R2");
        end

        // R3 / R8: arbitrary detection vectors
        do_reset();
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 5 == 0) step(1'b0, 2'($urandom), "R6");
            step(1'b1, 2'($urandom), "R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule